// File: doc/BRIEF.md
# ADC Conversion Sequencer with Hardware Averaging

This block times one complete conversion of a successive-approximation converter. All timing is counted in ticks of a derived converter clock. A start pulse with a channel number launches the conversion. The sequencer then passes through a fixed setup phase. For each sample it runs an acquisition phase of selectable length, followed by a fixed conversion phase. At the end of acquisition it strobes the analog core, and it collects the core's returned code before the conversion phase ends.

Averaging can be switched on. The samples are then summed, rounded and divided by a right shift. The averaged code is masked to the selected resolution and presented with a one-cycle done pulse. All configuration is latched at the start pulse. A continuous flag makes the sequencer relaunch on the same channel after every completion. A start on the reserved channel 31 stops activity and launches nothing.

The FSM states are IDLE, SETUP, SAMPLE and CONV. The transitions are named as follows:
- launch: any state to SETUP, on a start with a valid channel.
- kill: any state to IDLE, on a start with channel 31.
- setup_end: SETUP to SAMPLE.
- acq_end: SAMPLE to CONV; this transition issues the core strobe.
- next_sample: CONV to SAMPLE, when samples remain.
- finish: CONV to IDLE, on the last sample.
- relaunch: CONV to SETUP, on the last sample with the continuous flag set.

Top module: `adc_conv_seq`

## Requirements
- R1: One conversion lasts exactly 6 + N×(25 + L) converter-clock ticks. Count from the rising edge that samples start to the edge that registers done.
- R2: The acquisition adder L is set by a long flag and a 2-bit code. With the flag at 0, codes 0..3 give 3, 5, 7 and 9 ticks. With the flag at 1, codes 0..3 give 13, 17, 21 and 25 ticks.
- R3: N is 1 when averaging is off. With averaging on, the 2-bit count code 0..3 gives N = 4, 8, 16 and 32. The result is (sum + 2^(s-1)) >> s, where s = log2 N; for N = 1 there is no rounding term.
- R4: The converter tick period in input clocks is 2^div. It is doubled again when the half-rate source bit is 1, so div code 3 with that bit set gives 16.
- R5: Resolution code 0 masks the result to 0xFF, code 1 to 0x3FF, and code 2 to 0xFFF.
- R6: A start with channel 31 never launches a conversion. If a conversion is running, it is stopped: busy falls one cycle later and no done follows.
- R7: Out of reset, busy, done and result are 0. Busy rises the cycle after a launching start. In the done cycle busy is low unless continuous mode relaunches. Done lasts one cycle.
- R8: A start with a valid channel while busy abandons the current conversion. A new one starts on the new channel, timed from that start, and no done is given for the abandoned one.
- R9: With continuous mode set, a completion relaunches on the same channel. Consecutive done pulses are then one full conversion time apart. After the mode is cleared, the running conversion completes and no further one begins.
- R10: Configuration changes after the start pulse do not affect the running conversion's timing or result.
- R11: Exactly N core strobes are issued per conversion. Each strobe is issued while busy, with the core channel equal to the launched channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request pulse |
| chan | input | 5 | Channel for the request; 31 = off |
| cont_en | input | 1 | Relaunch after each completion |
| avg_en | input | 1 | Averaging enable |
| avg_cnt | input | 2 | Averaging count code |
| lsmp_long | input | 1 | Long acquisition range flag |
| lsmp_sel | input | 2 | Acquisition adder code |
| res_sel | input | 2 | Resolution code |
| clk_div | input | 2 | Converter clock divide code |
| src_half | input | 1 | Use half-rate source (extra ÷2) |
| core_sample | output | 1 | Strobe to analog core at end of acquisition |
| core_chan | output | 5 | Channel presented to the core |
| core_valid | input | 1 | Core data valid |
| core_data | input | 12 | Core sample code |
| result | output | 12 | Averaged, masked result |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Conversion in progress |

## Verification
Done and result are due at exactly T×D rising edges after the edge that samples start, where T is the R1 tick count and D is the R4 divide. Busy is due one edge after start. The bench drives inputs and reads outputs on falling edges and counts rising edges from the start edge. It requires done to appear on exactly the computed count, never earlier. In continuous mode the count restarts at each done, because the relaunch edge is also the done edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CHAN_W = 5;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SETUP,
        S_SAMPLE,
        S_CONV
    } seq_state_t;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              avg_en;
        logic [1:0]        avg_cnt;
        logic              lsmp_long;
        logic [1:0]        lsmp_sel;
        logic [1:0]        res_sel;
        logic [1:0]        clk_div;
        logic              src_half;
    } seq_cfg_t;

    // acquisition adder in ticks
    function automatic logic [4:0] lst_ticks(input logic long_f, input logic [1:0] sel);
        return long_f ? (5'd13 + {1'b0, sel, 2'b00}) : (5'd3 + {2'b00, sel, 1'b0});
    endfunction

    function automatic logic [5:0] avg_count(input logic en, input logic [1:0] cnt);
        return en ? (6'd4 << cnt) : 6'd1;
    endfunction

    function automatic logic [2:0] avg_shift(input logic en, input logic [1:0] cnt);
        return en ? (3'd2 + {1'b0, cnt}) : 3'd0;
    endfunction

endpackage

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] lim,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = en && (cnt == lim);

    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en) begin
            cnt <= '0;
        end else if (cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_avg_acc.sv
module adc_avg_acc #(
    parameter int DW = 12,
    parameter int AW = DW + 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add,
    input  logic [DW-1:0] din,
    input  logic [2:0]    shift,
    input  logic [1:0]    res_sel,
    output logic [DW-1:0] avg_out
);
    logic [AW-1:0] acc;
    logic [AW-1:0] sum;
    logic [AW:0]   rnd;
    logic [AW:0]   tot;
    logic [DW-1:0] q;
    logic [DW-1:0] mask;

    assign sum = acc + AW'(din);

    always_comb begin
        rnd  = (shift == 3'd0) ? '0 : ((AW+1)'(1) << (shift - 3'd1));
        tot  = {1'b0, sum} + rnd;
        q    = DW'(tot >> shift);
        mask = '1;
        unique case (res_sel)
            2'd0:    mask = mask >> (DW - 8);
            2'd1:    mask = mask >> (DW - 10);
            default: mask = '1;
        endcase
        avg_out = q & mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (add) begin
            acc <= sum;
        end
    end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SETUP_TICKS = 6,
    parameter int BASE_TICKS  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CHAN_W-1:0] chan,
    input  logic              cont_en,
    input  logic              avg_en,
    input  logic [1:0]        avg_cnt,
    input  logic              lsmp_long,
    input  logic [1:0]        lsmp_sel,
    input  logic [1:0]        res_sel,
    input  logic [1:0]        clk_div,
    input  logic              src_half,
    output logic              core_sample,
    output logic [CHAN_W-1:0] core_chan,
    input  logic              core_valid,
    input  logic [DATA_W-1:0] core_data,
    output logic [DATA_W-1:0] result,
    output logic              done,
    output logic              busy
);
    localparam int TW = 5;
    localparam int DIV_W = 4;
    localparam logic [CHAN_W-1:0] CHAN_OFF = '1;
    localparam logic [TW-1:0] SETUP_LD = TW'(SETUP_TICKS - 1);
    localparam logic [TW-1:0] BASE_LD  = TW'(BASE_TICKS - 1);

    seq_state_t state, nxt;
    seq_cfg_t   cfg_in, cfg_q, cfg_use;

    logic [TW-1:0]     tcnt;
    logic [5:0]        ncnt;
    logic [DATA_W-1:0] samp_q;
    logic [DATA_W-1:0] avg_val;
    logic [4:0]        lst;
    logic [4:0]        div_n;
    logic [DIV_W-1:0]  div_lim;
    logic start_ok, start_kill, tick, last_tick, fin, restart, acc_add;

    always_comb begin
        cfg_in.chan      = chan;
        cfg_in.avg_en    = avg_en;
        cfg_in.avg_cnt   = avg_cnt;
        cfg_in.lsmp_long = lsmp_long;
        cfg_in.lsmp_sel  = lsmp_sel;
        cfg_in.res_sel   = res_sel;
        cfg_in.clk_div   = clk_div;
        cfg_in.src_half  = src_half;
    end

    assign start_ok   = start && (chan != CHAN_OFF);
    assign start_kill = start && (chan == CHAN_OFF);
    assign cfg_use    = start_ok ? cfg_in : cfg_q;
    assign lst        = lst_ticks(cfg_q.lsmp_long, cfg_q.lsmp_sel);
    assign div_n      = 5'd1 << ({1'b0, cfg_q.clk_div} + {2'b00, cfg_q.src_half});
    assign div_lim    = DIV_W'(div_n - 5'd1);
    assign last_tick  = tick && (tcnt == '0);
    assign fin        = (state == S_CONV) && last_tick && (ncnt == 6'd1);
    assign restart    = start_ok || (fin && cont_en && !start_kill);
    assign acc_add    = (state == S_CONV) && last_tick;
    assign busy       = (state != S_IDLE);
    assign core_chan  = cfg_q.chan;

    adc_tick_div #(.CW(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (restart),
        .en   (busy),
        .lim  (div_lim),
        .tick (tick)
    );

    adc_avg_acc #(.DW(DATA_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (restart || start_kill),
        .add    (acc_add),
        .din    (samp_q),
        .shift  (avg_shift(cfg_q.avg_en, cfg_q.avg_cnt)),
        .res_sel(cfg_q.res_sel),
        .avg_out(avg_val)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   nxt = S_IDLE;
            S_SETUP:  if (last_tick) nxt = S_SAMPLE;
            S_SAMPLE: if (last_tick) nxt = S_CONV;
            S_CONV:   if (last_tick) nxt = (ncnt == 6'd1) ? (cont_en ? S_SETUP : S_IDLE) : S_SAMPLE;
        endcase
        if (start_ok) begin
            nxt = S_SETUP;
        end else if (start_kill) begin
            nxt = S_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // phase counters and latched configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt   <= '0;
            ncnt   <= '0;
            cfg_q  <= '0;
            samp_q <= '0;
        end else begin
            if (start_ok) cfg_q <= cfg_in;
            if (core_valid) samp_q <= core_data;
            if (restart) begin
                tcnt <= SETUP_LD;
                ncnt <= avg_count(cfg_use.avg_en, cfg_use.avg_cnt);
            end else if (tick) begin
                if (tcnt != '0) begin
                    tcnt <= tcnt - 1'b1;
                end else begin
                    case (state)
                        S_SETUP:  tcnt <= TW'(lst - 5'd1);
                        S_SAMPLE: tcnt <= BASE_LD;
                        S_CONV: begin
                            tcnt <= TW'(lst - 5'd1);
                            ncnt <= ncnt - 6'd1;
                        end
                        default: tcnt <= '0;
                    endcase
                end
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            result      <= '0;
            core_sample <= 1'b0;
        end else begin
            done        <= fin && !start;
            core_sample <= (state == S_SAMPLE) && last_tick && !start;
            if (fin && !start) result <= avg_val;
        end
    end
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [4:0] chan,
    input logic       done,
    input logic       busy,
    input logic       core_sample,
    input logic [4:0] core_chan
);
    // R6
    off_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && chan == 5'h1F) |=> (!busy && !done));

    // R8
    relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && chan != 5'h1F) |=> (busy && !done));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R11
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_sample |-> busy);

    // R11
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(start)) |-> $stable(core_chan));
endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .chan       (chan),
    .done       (done),
    .busy       (busy),
    .core_sample(core_sample),
    .core_chan  (core_chan)
);

// File: tb/sim_adc_conv_seq.sv
`timescale 1ns/1ps
module sim_adc_conv_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [4:0] chan = '0;
    logic cont_en = 1'b0;
    logic avg_en = 1'b0;
    logic [1:0] avg_cnt = '0;
    logic lsmp_long = 1'b0;
    logic [1:0] lsmp_sel = '0;
    logic [1:0] res_sel = 2'd2;
    logic [1:0] clk_div = '0;
    logic src_half = 1'b0;
    logic core_sample;
    logic [4:0] core_chan;
    logic core_valid;
    logic [11:0] core_data;
    logic [11:0] result;
    logic done, busy;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adc_conv_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .cont_en(cont_en),
        .avg_en(avg_en), .avg_cnt(avg_cnt), .lsmp_long(lsmp_long), .lsmp_sel(lsmp_sel),
        .res_sel(res_sel), .clk_div(clk_div), .src_half(src_half),
        .core_sample(core_sample), .core_chan(core_chan), .core_valid(core_valid),
        .core_data(core_data), .result(result), .done(done), .busy(busy)
    );

    // mock analog core: answers three cycles after each strobe
    int mseed = 0;
    int mk = 0;
    logic [2:0] vp = '0;
    logic [11:0] mdat = '0;
    always @(posedge clk) begin
        vp <= {vp[1:0], core_sample === 1'b1};
        if (core_sample === 1'b1) mdat <= 12'((mseed + 613 * mk) % 4096);
        if (start) mk <= 0;
        else if (core_sample === 1'b1) mk <= mk + 1;
    end
    assign core_valid = vp[2];
    assign core_data  = mdat;

    // {avg_en, avg_cnt, lsmp_long, lsmp_sel, res_sel, clk_div, src_half, chan}
    localparam logic [15:0] VEC [0:11] = '{
        {1'b0, 2'd0, 1'b0, 2'd0, 2'd2, 2'd0, 1'b0, 5'd3},
        {1'b0, 2'd0, 1'b0, 2'd1, 2'd2, 2'd0, 1'b0, 5'd5},
        {1'b0, 2'd0, 1'b0, 2'd2, 2'd1, 2'd1, 1'b0, 5'd1},
        {1'b0, 2'd0, 1'b0, 2'd3, 2'd0, 2'd0, 1'b0, 5'd0},
        {1'b0, 2'd0, 1'b1, 2'd0, 2'd2, 2'd0, 1'b0, 5'd7},
        {1'b0, 2'd0, 1'b1, 2'd1, 2'd2, 2'd2, 1'b0, 5'd2},
        {1'b0, 2'd0, 1'b1, 2'd2, 2'd2, 2'd0, 1'b0, 5'd9},
        {1'b0, 2'd0, 1'b1, 2'd3, 2'd2, 2'd0, 1'b1, 5'd4},
        {1'b1, 2'd0, 1'b0, 2'd0, 2'd2, 2'd0, 1'b0, 5'd6},
        {1'b1, 2'd1, 1'b0, 2'd2, 2'd1, 2'd0, 1'b0, 5'd8},
        {1'b1, 2'd2, 1'b1, 2'd0, 2'd2, 2'd1, 1'b0, 5'd10},
        {1'b1, 2'd3, 1'b1, 2'd3, 2'd2, 2'd3, 1'b1, 5'd15}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int v_lst(logic [15:0] v);
        return v[12] ? (13 + 4 * int'(v[11:10])) : (3 + 2 * int'(v[11:10]));
    endfunction
    function automatic int v_n(logic [15:0] v);
        return v[15] ? (4 << v[14:13]) : 1;
    endfunction
    function automatic int v_sh(logic [15:0] v);
        return v[15] ? (2 + int'(v[14:13])) : 0;
    endfunction
    function automatic int v_div(logic [15:0] v);
        return (1 << v[7:6]) << v[5];
    endfunction
    function automatic int v_ticks(logic [15:0] v);
        return 6 + v_n(v) * (25 + v_lst(v));
    endfunction
    function automatic int exp_res(int seed, int k0, logic [15:0] v);
        int sum = 0;
        int sh = v_sh(v);
        for (int i = 0; i < v_n(v); i++) sum += (seed + 613 * (k0 + i)) % 4096;
        if (sh > 0) sum += 1 << (sh - 1);
        sum = sum >> sh;
        case (v[9:8])
            2'd0: return sum & 'hFF;
            2'd1: return sum & 'h3FF;
            default: return sum & 'hFFF;
        endcase
    endfunction

    task automatic apply_cfg(input logic [15:0] v);
        avg_en = v[15]; avg_cnt = v[14:13]; lsmp_long = v[12]; lsmp_sel = v[11:10];
        res_sel = v[9:8]; clk_div = v[7:6]; src_half = v[5]; chan = v[4:0];
    endtask

    // pulse start for one edge; returns at the falling edge after it
    task automatic do_start(input logic [15:0] v);
        @(negedge clk);
        apply_cfg(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // count rising edges until done is seen; also count strobes
    task automatic wait_done(input int limit, output int n, output int strobes);
        n = 0;
        strobes = 0;
        while (n < limit) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (core_sample) strobes++;
            if (done) break;
        end
    endtask

    task automatic no_done(input int cycles, output int seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (done) seen++;
        end
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            fails++;
            total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int n, s, seen, exp_n;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk(busy == 1'b0 && done == 1'b0 && result == 12'd0, "R7 reset outputs", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R2 R3 R4 R5 R11
        for (int i = 0; i < 12; i++) begin
            v = VEC[i];
            mseed = (3000 + 701 * i) % 4096;
            do_start(v);
            chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
            exp_n = v_ticks(v) * v_div(v);
            wait_done(exp_n + 50, n, s);
            chk(n == exp_n, "R1 R2 R4 done timing", n, exp_n);
            chk(int'(result) == exp_res(mseed, 0, v), "R3 R5 result", int'(result), exp_res(mseed, 0, v));
            chk(s == v_n(v), "R11 strobe count", s, v_n(v));
            chk(busy == 1'b0, "R7 busy low at done", int'(busy), 0);
            @(negedge clk);
            chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
        end

        // R6 off channel while idle
        v = {1'b0, 2'd0, 1'b0, 2'd0, 2'd2, 2'd0, 1'b0, 5'd31};
        do_start(v);
        chk(busy == 1'b0, "R6 idle off start", int'(busy), 0);
        no_done(100, seen);
        chk(seen == 0 && busy == 1'b0, "R6 no done idle", seen, 0);

        // R6 off channel stops a running conversion
        do_start(VEC[0]);
        repeat (10) @(negedge clk);
        do_start(v);
        chk(busy == 1'b0, "R6 stop running", int'(busy), 0);
        no_done(100, seen);
        chk(seen == 0, "R6 no done after stop", seen, 0);

        // R8 restart with new channel
        mseed = 1234;
        do_start(VEC[0]);
        repeat (15) @(negedge clk);
        v = VEC[0];
        v[4:0] = 5'd6;
        do_start(v);
        chk(core_chan == 5'd6, "R8 new channel", int'(core_chan), 6);
        wait_done(200, n, s);
        chk(n == 34, "R8 timing from restart", n, 34);
        chk(int'(result) == exp_res(1234, 0, v), "R8 result", int'(result), exp_res(1234, 0, v));

        // R10 configuration changed mid-conversion
        mseed = 3777;
        do_start(VEC[0]);
        avg_en = 1'b1; lsmp_long = 1'b1; res_sel = 2'd0; clk_div = 2'd3; chan = 5'd12;
        wait_done(5000, n, s);
        chk(n == 34, "R10 timing unchanged", n, 34);
        chk(int'(result) == exp_res(3777, 0, VEC[0]), "R10 result unchanged", int'(result), exp_res(3777, 0, VEC[0]));

        // R9 continuous mode
        mseed = 2500;
        cont_en = 1'b1;
        do_start(VEC[0]);
        wait_done(200, n, s);
        chk(n == 34, "R9 first done", n, 34);
        chk(busy == 1'b1, "R9 busy kept", int'(busy), 1);
        wait_done(200, n, s);
        chk(n == 34, "R9 period", n, 34);
        chk(int'(result) == exp_res(2500, 1, VEC[0]), "R9 second result", int'(result), exp_res(2500, 1, VEC[0]));
        chk(core_chan == 5'd3, "R9 same channel", int'(core_chan), 3);
        cont_en = 1'b0;
        wait_done(200, n, s);
        chk(n == 34 && busy == 1'b0, "R9 final done", n, 34);
        no_done(120, seen);
        chk(seen == 0 && busy == 1'b0, "R9 stopped", seen, 0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule